// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns 32-bit device virtual addresses into physical addresses. A small fully associative translation cache answers repeated pages in one cycle. On a miss, the block reads a level-1 entry and then a level-2 entry from memory. It fills the cache and then returns the physical address. Table entries have no valid flag. Regions with no mapping point to a shared filler level-2 table, and that table points to a filler page. Every walk therefore ends with an address, and there is no fault output.

A device presents an address with a valid/ready handshake and receives a one-cycle response pulse. Table entries arrive through a simple read port: the block raises a one-cycle read strobe with an address, and the memory later returns one data word with a valid pulse. Software uses three registers. One holds the frame number of the level-1 table. Writing all ones to a second register starts a cache flush. A third register shows whether the flush is still in progress.

Top module: `iommu_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_en` are 0, and register reads at select 0 (table base) and select 2 (status) return 0.
- R2: On a cache miss, exactly two memory reads are issued in order. The first is at ({base[19:0],12'h000} + 4*va[31:22]). The second is at ({L1 entry[19:0],12'h000} + 4*va[21:12]). Each read strobe lasts one cycle.
- R3: A walk ends with a one-cycle `rsp_valid` pulse, in the cycle after the level-2 data arrives, with `rsp_paddr` = {L2 entry[19:0], va[11:0]}.
- R4: A request whose page (va[31:12]) is in the cache gets `rsp_valid` in the cycle after acceptance, with no memory read, and its low 12 address bits are unchanged.
- R5: Only one walk is in flight: `req_ready` stays 0 from the acceptance of a missing request until its response.
- R6: Register select 0 holds a 27-bit table base frame number, written from `reg_wdata[26:0]`. It reads back zero-extended.
- R7: Writing 32'hFFFFFFFF to select 1 invalidates every cache entry. Any other value written there has no effect.
- R8: Status bit 0 at select 2 reads 1 from the cycle after a flush write until the flush completes, which takes TLB_ENTRIES cycles. `req_ready` is 0 meanwhile.
- R9: The cache holds TLB_ENTRIES pages, filled in round-robin order. With the default of 8 entries, the ninth distinct page after a flush evicts the first page that was filled.
- R10: Entries carry no valid flag. A level-1 entry that points to the filler table still yields a completed walk and a physical address inside the filler page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Translated physical address |
| mem_rd_en | output | 1 | One-cycle table read strobe |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Table entry value |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 invalidate, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |

## Verification
The assertions check the following on every cycle:
- Read strobes stay one cycle long.
- No request is accepted while a read is out.
- A cache hit answers on the next cycle with its page offset unchanged.
- A walk response carries the frame number that the memory just returned.
- A flush write raises the busy bit.

The bench scenarios cover the behaviours that only show up across sequences:
- exact table addresses and result values for mapped and filler regions;
- the base register changing where walks start;
- the ignored non-all-ones invalidate write;
- the round-robin eviction order over nine pages.

// File: rtl/iommu_walker.sv
module iommu_walker #(
  parameter int TLB_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int IW    = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;
  localparam int PG    = 12;
  localparam int PFN_W = 32 - PG;
  localparam int BASE_W = 27;

  typedef enum logic [2:0] {IDLE, L1_RD, L1_WT, L2_RD, L2_WT} st_t;
  st_t st;

  logic [BASE_W-1:0]      base_pfn;
  logic [TLB_ENTRIES-1:0] vld;
  logic [PFN_W-1:0]       tag [TLB_ENTRIES];
  logic [PFN_W-1:0]       pfn [TLB_ENTRIES];
  logic [IW-1:0]          victim, sweep;
  logic                   busy;
  logic [31:0]            va_q;
  logic [PFN_W-1:0]       l1_q;
  logic                   hit;
  logic [IW-1:0]          hit_idx;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < TLB_ENTRIES; i++)
      if (!hit && vld[i] && tag[i] == req_vaddr[31:PG]) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
  end

  assign req_ready = (st == IDLE) && !busy;
  wire accept   = req_valid && req_ready;
  wire flush_wr = reg_wr && reg_sel == 2'd1 && reg_wdata == 32'hFFFF_FFFF;
  wire fill     = (st == L2_WT) && mem_rd_valid;

  assign mem_rd_en   = (st == L1_RD) || (st == L2_RD);
  assign mem_rd_addr = (st == L2_RD || st == L2_WT)
                     ? {l1_q, 12'h000} + {20'h0, va_q[21:12], 2'b00}
                     : {base_pfn[PFN_W-1:0], 12'h000} + {20'h0, va_q[31:22], 2'b00};

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {{(32-BASE_W){1'b0}}, base_pfn};
      2'd2:    reg_rdata = {31'h0, busy};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag[victim] <= va_q[31:PG];
      pfn[victim] <= mem_rd_data[PFN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      base_pfn  <= '0;
      vld       <= '0;
      victim    <= '0;
      sweep     <= '0;
      busy      <= 1'b0;
      va_q      <= '0;
      l1_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (reg_wr && reg_sel == 2'd0) base_pfn <= reg_wdata[BASE_W-1:0];
      case (st)
        IDLE: if (accept) begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= {pfn[hit_idx], req_vaddr[PG-1:0]};
          end else begin
            va_q <= req_vaddr;
            st   <= L1_RD;
          end
        end
        L1_RD: st <= L1_WT;
        L1_WT: if (mem_rd_valid) begin
          l1_q <= mem_rd_data[PFN_W-1:0];
          st   <= L2_RD;
        end
        L2_RD: st <= L2_WT;
        L2_WT: if (mem_rd_valid) begin
          vld[victim] <= 1'b1;
          victim      <= (victim == IW'(TLB_ENTRIES-1)) ? '0 : victim + 1'b1;
          rsp_valid   <= 1'b1;
          rsp_paddr   <= {mem_rd_data[PFN_W-1:0], va_q[PG-1:0]};
          st          <= IDLE;
        end
        default: st <= IDLE;
      endcase
      if (busy) begin
        vld[sweep] <= 1'b0;
        sweep <= (sweep == IW'(TLB_ENTRIES-1)) ? '0 : sweep + 1'b1;
        if (sweep == IW'(TLB_ENTRIES-1)) busy <= 1'b0;
      end else if (flush_wr) begin
        busy  <= 1'b1;
        sweep <= '0;
      end
    end
  end

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
  // R5
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);
  // R4
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (rsp_valid && rsp_paddr[PG-1:0] == $past(req_vaddr[PG-1:0])));
  // R3
  walk_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (rsp_valid && rsp_paddr[31:PG] == $past(mem_rd_data[PFN_W-1:0])));
  // R7
  flush_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> busy);
endmodule

// File: tb/iommu_walker_tb.sv
module iommu_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid, mem_rd_en, mem_rd_valid = 0;
  logic [31:0] req_vaddr = 0, rsp_paddr, mem_rd_addr, mem_rd_data = 0;
  logic reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int checks = 0, errors = 0, rd_cnt = 0;
  logic [31:0] prev_addr = 0, cur_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_walker #(.TLB_ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // Table image: L1 at frame 0x100 (index 1 -> 0x200, else filler 0x300),
  // L1 at frame 0x400 (all -> 0x200), L2 at 0x200 (0x5000+j), filler L2 all 0x700.
  function automatic logic [31:0] model(input logic [31:0] a);
    logic [31:0] idx = (a & 32'hFFF) >> 2;
    case (a[31:12])
      20'h100: return (idx == 1) ? 32'h200 : 32'h300;
      20'h400: return 32'h200;
      20'h200: return 32'h5000 + idx;
      20'h300: return 32'h700;
      default: return 32'hDEAD;
    endcase
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      prev_addr <= cur_addr;
      cur_addr <= mem_rd_addr;
      mem_rd_valid <= 1'b1;
      mem_rd_data <= model(mem_rd_addr);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa,
                       output int nrd, output int lat);
    int start;
    @(negedge clk); req_valid = 1; req_vaddr = va; start = rd_cnt;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0; lat = 1;
    while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
    pa = rsp_paddr; nrd = rd_cnt - start;
  endtask

  task automatic t_reset();
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 mem_rd_en", mem_rd_en, 0);
    reg_sel = 0; #1 check("R1 base", reg_rdata, 0);
    reg_sel = 2; #1 check("R1 status", reg_rdata, 0);
  endtask

  task automatic t_walk_mapped();
    logic [31:0] pa; int n, l;
    wr(0, 32'h100);
    xlate(32'h0041_2345, pa, n, l);
    check("R2 read count", n, 2);
    check("R2 L1 addr", prev_addr, 32'h0010_0004);
    check("R2 L2 addr", cur_addr, 32'h0020_0048);
    check("R3 paddr", pa, 32'h0501_2345);
  endtask

  task automatic t_walk_filler();
    logic [31:0] pa; int n, l;
    xlate(32'h8000_0ABC, pa, n, l);
    check("R10 L1 addr", prev_addr, 32'h0010_0800);
    check("R10 L2 addr", cur_addr, 32'h0030_0000);
    check("R10 paddr", pa, 32'h0070_0ABC);
  endtask

  task automatic t_hit();
    logic [31:0] pa; int n, l;
    xlate(32'h0041_2FFF, pa, n, l);
    check("R4 reads", n, 0);
    check("R4 latency", l, 1);
    check("R4 paddr", pa, 32'h0501_2FFF);
  endtask

  task automatic t_one_walk();
    int busy_low = 1;
    @(negedge clk); req_valid = 1; req_vaddr = 32'h0047_7000;
    @(negedge clk); req_valid = 0;
    while (!rsp_valid) begin
      if (req_ready) busy_low = 0;
      @(negedge clk);
    end
    check("R5 ready low during walk", busy_low, 1);
    check("R5 paddr", rsp_paddr, 32'h0507_7000);
  endtask

  task automatic t_flush();
    logic [31:0] pa; int n, l;
    wr(1, 32'hFFFF_FFFF);
    reg_sel = 2; #1;
    check("R8 busy set", reg_rdata, 1);
    check("R8 ready low", req_ready, 0);
    repeat (N + 2) @(negedge clk);
    reg_sel = 2; #1 check("R8 busy cleared", reg_rdata, 0);
    xlate(32'h0041_2345, pa, n, l);
    check("R7 flushed page misses", n, 2);
    wr(1, 32'h0000_0001);
    reg_sel = 2; #1 check("R7 other value no busy", reg_rdata, 0);
    xlate(32'h0041_2345, pa, n, l);
    check("R7 other value keeps entry", n, 0);
  endtask

  task automatic t_base();
    logic [31:0] pa; int n, l;
    wr(0, 32'hFFFF_FFFF);
    reg_sel = 0; #1 check("R6 base width", reg_rdata, 32'h07FF_FFFF);
    wr(0, 32'h400);
    reg_sel = 0; #1 check("R6 base readback", reg_rdata, 32'h400);
    xlate(32'h8000_5000, pa, n, l);
    check("R6 L1 addr from base", prev_addr, 32'h0040_0800);
    check("R6 paddr", pa, 32'h0500_5000);
    wr(0, 32'h100);
  endtask

  task automatic t_round_robin();
    logic [31:0] pa; int n, l;
    wr(1, 32'hFFFF_FFFF);
    repeat (N + 2) @(negedge clk);
    for (int k = 0; k < N; k++) xlate(32'h0040_0000 + (k << 12), pa, n, l);
    for (int k = 0; k < N; k++) begin
      xlate(32'h0040_0000 + (k << 12), pa, n, l);
      check("R9 all resident", n, 0);
      check("R9 resident paddr", pa, 32'h0500_0000 + (k << 12));
    end
    xlate(32'h0040_0000 + (N << 12), pa, n, l);
    check("R9 extra page miss", n, 2);
    xlate(32'h0040_0000, pa, n, l);
    check("R9 first page evicted", n, 2);
    xlate(32'h0040_2000, pa, n, l);
    check("R9 third page kept", n, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_walk_mapped();
    t_walk_filler();
    t_hit();
    t_one_walk();
    t_flush();
    t_base();
    t_round_robin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule